// File: doc/BRIEF.md
# Display Data Channel Mode Controller

This block governs the operating mode of one display data channel whose two pins are shared with general-purpose I/O. It runs entirely in the system clock domain. From reset the pins belong to plain I/O. When software drives the active-low enable to 0, the channel comes up in the unidirectional transmit mode, where a data byte is clocked out by the vertical sync signal.

While the channel is unidirectional, the controller measures how long the synchronized SCL line stays low. A low period longer than 500 ns means that a host wants two-way traffic, so the channel moves to the bidirectional slave mode. Software can send the channel back to unidirectional operation with a return request. It can also start master operation directly from the unidirectional mode with a master-start pulse. Setting the enable to 1 returns the pins to I/O from any mode.

The block drives the current mode, the pin-function selects and a one-cycle mode-change pulse. The protocol engine, the pad cells and the register file use these outputs.

Top module: `ddc_mode_ctrl`

## Requirements
- R1: During and after reset, and before enabling, `mode` is 0 (I/O), `sda_sel` and `scl_sel` are 0, and `mode_chg` is 0.
- R2: When `mode` is 0 and `en_n` is 0 at a clock edge, `mode` becomes 1 (unidirectional) at that edge.
- R3: In mode 1, once the two-flop-synchronized SCL has been sampled low on LOW_CYC consecutive edges (LOW_CYC = LOW_NS*1000/CLK_PS + 1, giving 126 cycles of 4 ns = 504 ns), `mode` becomes 2 (bidirectional slave) on the next edge. A shorter low period leaves the mode at 1.
- R4: Any high synchronized SCL sample restarts the low-time measurement from zero.
- R5: A `mst_go` pulse in mode 1 moves `mode` to 3 (master), and it wins over a long-low detection at the same edge. `mst_go` has no effect in modes 0, 2 and 3.
- R6: A `ret_req` pulse in mode 2 or 3 moves `mode` to 1. `ret_req` has no effect in modes 0 and 1.
- R7: `en_n` = 1 at an edge forces `mode` to 0 from any mode and clears the low-time measurement.
- R8: `mode_chg` is high for exactly the first cycle in which `mode` shows a new value, and is low otherwise.
- R9: `sda_sel` is 1 in modes 1, 2 and 3. `scl_sel` is 1 only in modes 2 and 3.
- R10: Every mode change clears the low-time measurement, so after a return to mode 1 a new full LOW_CYC low period is needed to reach mode 2, even if SCL stayed low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_pin | input | 1 | Raw SCL level from the pad, asynchronous |
| en_n | input | 1 | Channel enable, active low |
| ret_req | input | 1 | One-cycle request to return to unidirectional mode |
| mst_go | input | 1 | One-cycle request to start master operation |
| mode | output | 2 | Current mode: 0 I/O, 1 unidirectional, 2 bidirectional slave, 3 master |
| mode_chg | output | 1 | One-cycle pulse on every mode change |
| sda_sel | output | 1 | SDA pin taken by the channel function |
| scl_sel | output | 1 | SCL pin taken by the channel function |

## Verification
A wrong low-time count shows up as an early or late move from mode 1 to mode 2. The cycle-exact reference in the bench catches it on the first clock where the two disagree, which is at most LOW_CYC+3 cycles after SCL falls. A stale counter after a mode change, or a dropped priority between the master request and the long-low detection, shows up as an unexpected mode 2 or 3 one edge after the decision. A mode register that holds a wrong value is visible at once on `mode`, on the pin selects and on the missing or extra `mode_chg` pulse.

// File: rtl/ddc_mode_pkg.sv
package ddc_mode_pkg;
    typedef enum logic [1:0] {
        CH_IO     = 2'd0,
        CH_UNI    = 2'd1,
        CH_BIDIR  = 2'd2,
        CH_MASTER = 2'd3
    } ch_mode_e;

    function automatic int unsigned low_cycles(input int unsigned low_ns, input int unsigned clk_ps);
        return (low_ns * 1000) / clk_ps + 1;
    endfunction
endpackage

// File: rtl/ddc_scl_sync.sv
module ddc_scl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ddc_low_meter.sv
module ddc_low_meter #(
    parameter int unsigned LOW_CYC = 126,
    localparam int unsigned CW = $clog2(LOW_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic clr,
    output logic long_low
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } meter_t;

    meter_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr || scl_s)
            st_d.cnt = '0;
        else if (st_q.cnt < CW'(LOW_CYC))
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign long_low = (st_q.cnt >= CW'(LOW_CYC));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(LOW_CYC));
    // R4
    high_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_s |=> (st_q.cnt == '0));
    // R10
    clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !long_low);
endmodule

// File: rtl/ddc_mode_fsm.sv
module ddc_mode_fsm
    import ddc_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_n,
    input  logic     ret_req,
    input  logic     mst_go,
    input  logic     long_low,
    output ch_mode_e mode_o,
    output logic     chg_o,
    output logic     chg_now_o
);
    typedef struct packed {
        ch_mode_e mode;
        logic     chg;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_n) begin
            st_d.mode = CH_IO;
        end else begin
            unique case (st_q.mode)
                CH_IO:  st_d.mode = CH_UNI;
                CH_UNI: begin
                    if (mst_go)        st_d.mode = CH_MASTER;
                    else if (long_low) st_d.mode = CH_BIDIR;
                end
                CH_BIDIR, CH_MASTER: begin
                    if (ret_req) st_d.mode = CH_UNI;
                end
                default: st_d.mode = CH_IO;
            endcase
        end
        st_d.chg = (st_d.mode != st_q.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: CH_IO, chg: 1'b0};
        else        st_q <= st_d;
    end

    assign mode_o    = st_q.mode;
    assign chg_o     = st_q.chg;
    assign chg_now_o = st_d.chg;

    // R2
    enable_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CH_IO && !en_n) |=> (st_q.mode == CH_UNI));
    // R7
    disable_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> (st_q.mode == CH_IO));
    // R5
    master_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CH_UNI && mst_go && !en_n) |=> (st_q.mode == CH_MASTER));
    // R6
    return_uni_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == CH_BIDIR || st_q.mode == CH_MASTER) && ret_req && !en_n)
            |=> (st_q.mode == CH_UNI));
    // R3
    bidir_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CH_UNI && !long_low && !en_n) |=> (st_q.mode != CH_BIDIR));
    // R8
    chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.chg |-> (st_q.mode != $past(st_q.mode)));
    // R8
    chg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.chg |-> $stable(st_q.mode));
endmodule

// File: rtl/ddc_mode_ctrl.sv
module ddc_mode_ctrl
    import ddc_mode_pkg::*;
#(
    parameter int unsigned CLK_PS      = 4000,
    parameter int unsigned LOW_NS      = 500,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned LOW_CYC    = low_cycles(LOW_NS, CLK_PS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_pin,
    input  logic       en_n,
    input  logic       ret_req,
    input  logic       mst_go,
    output logic [1:0] mode,
    output logic       mode_chg,
    output logic       sda_sel,
    output logic       scl_sel
);
    logic     scl_s;
    logic     long_low;
    logic     chg_now;
    ch_mode_e cur_mode;

    ddc_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (scl_pin),
        .sync_o  (scl_s)
    );

    ddc_low_meter #(.LOW_CYC(LOW_CYC)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .clr      (en_n | chg_now),
        .long_low (long_low)
    );

    ddc_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_n      (en_n),
        .ret_req   (ret_req),
        .mst_go    (mst_go),
        .long_low  (long_low),
        .mode_o    (cur_mode),
        .chg_o     (mode_chg),
        .chg_now_o (chg_now)
    );

    assign mode    = cur_mode;
    assign sda_sel = (cur_mode != CH_IO);
    assign scl_sel = (cur_mode == CH_BIDIR) || (cur_mode == CH_MASTER);

    // R9
    sel_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_sel |-> sda_sel);
    // R1
    io_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (!sda_sel && !scl_sel));
endmodule

// File: tb/test_ddc_mode_ctrl.sv
module test_ddc_mode_ctrl;
    localparam int LOW = 500 * 1000 / 4000 + 1;

    logic clk = 0, rst_n = 0;
    logic scl_pin = 1, en_n = 1, ret_req = 0, mst_go = 0;
    logic [1:0] mode;
    logic mode_chg, sda_sel, scl_sel;

    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    int m_s1 = 1, m_s2 = 1, m_cnt = 0, m_mode = 0, m_chg = 0;

    ddc_mode_ctrl i_ddc_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_pin(scl_pin), .en_n(en_n),
        .ret_req(ret_req), .mst_go(mst_go), .mode(mode),
        .mode_chg(mode_chg), .sda_sel(sda_sel), .scl_sel(scl_sel)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int nm, ch;
        cycles++;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_cnt = 0; m_mode = 0; m_chg = 0;
        end else begin
            nm = m_mode;
            if (en_n) nm = 0;
            else if (m_mode == 0) nm = 1;
            else if (m_mode == 1) begin
                if (mst_go) nm = 3;
                else if (m_cnt >= LOW) nm = 2;
            end else if (ret_req) nm = 1;
            ch = (nm != m_mode) ? 1 : 0;
            if (en_n || ch != 0 || m_s2 == 1) m_cnt = 0;
            else if (m_cnt < LOW) m_cnt++;
            m_s2 = m_s1; m_s1 = scl_pin; m_mode = nm; m_chg = ch;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(mode == m_mode, cur_req, mode, m_mode);
            chk(mode_chg == m_chg, "R8", mode_chg, m_chg);
            chk(sda_sel == (m_mode != 0), "R9", sda_sel, m_mode != 0);
            chk(scl_sel == (m_mode >= 2), "R9", scl_sel, m_mode >= 2);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ret();
        ret_req = 1; step(1); ret_req = 0;
    endtask

    task automatic pulse_mst();
        mst_go = 1; step(1); mst_go = 0;
    endtask

    initial begin
        step(3);
        // R1: reset state
        chk(mode == 0 && !sda_sel && !scl_sel && !mode_chg, "R1", mode, 0);
        rst_n = 1;
        step(4);
        chk(mode == 0, "R1", mode, 0);
        // R6: return request ignored in I/O
        cur_req = "R6"; pulse_ret(); step(1);
        chk(mode == 0, "R6", mode, 0);

        cur_req = "R2"; en_n = 0; step(1);
        chk(mode == 1, "R2", mode, 1);
        // R6: return ignored in unidirectional
        cur_req = "R6"; pulse_ret(); step(1);
        chk(mode == 1, "R6", mode, 1);

        // R3: short low stays unidirectional
        cur_req = "R3"; scl_pin = 0; step(LOW - 20); scl_pin = 1; step(5);
        chk(mode == 1, "R3", mode, 1);
        // R4: high glitch restarts the measurement
        cur_req = "R4"; scl_pin = 0; step(LOW - 10); scl_pin = 1; step(1);
        scl_pin = 0; step(LOW - 10);
        chk(mode == 1, "R4", mode, 1);
        // R3: long low enters bidirectional
        cur_req = "R3"; step(30);
        chk(mode == 2, "R3", mode, 2);
        chk(scl_sel == 1, "R9", scl_sel, 1);
        // R5: master request ignored in bidirectional
        cur_req = "R5"; pulse_mst(); step(1);
        chk(mode == 2, "R5", mode, 2);

        // R10: return with SCL still low needs a new full measurement
        cur_req = "R10"; pulse_ret();
        chk(mode == 1, "R6", mode, 1);
        step(LOW - 30);
        chk(mode == 1, "R10", mode, 1);
        step(40);
        chk(mode == 2, "R10", mode, 2);
        scl_pin = 1;

        // R5: master start from unidirectional
        cur_req = "R5"; pulse_ret(); step(2);
        pulse_mst();
        chk(mode == 3, "R5", mode, 3);
        pulse_mst(); step(1);
        chk(mode == 3, "R5", mode, 3);
        cur_req = "R6"; pulse_ret();
        chk(mode == 1, "R6", mode, 1);

        // R5: master wins over long-low at the same edge
        cur_req = "R5"; scl_pin = 0; step(LOW + 2);
        pulse_mst();
        chk(mode == 3, "R5", mode, 3);
        scl_pin = 1; step(3);

        // R7: disable from master and from bidirectional
        cur_req = "R7"; en_n = 1; step(1);
        chk(mode == 0 && !sda_sel, "R7", mode, 0);
        en_n = 0; step(1); scl_pin = 0; step(LOW + 5);
        chk(mode == 2, "R3", mode, 2);
        en_n = 1; step(1);
        chk(mode == 0, "R7", mode, 0);
        // R7: measurement cleared while disabled, re-enable needs full low again
        step(20); en_n = 0; step(LOW - 20);
        chk(mode == 1, "R7", mode, 1);
        step(30);
        chk(mode == 2, "R7", mode, 2);
        scl_pin = 1; step(5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule